// File: doc/BRIEF.md
# Host-to-Controller Handshake Port

This block is a small memory-mapped port that joins a byte-wide 6502-style host bus to a slower microcontroller running on its own clock. The host writes a command byte to the data offset. The port latches the byte and raises a request level toward the controller. The host never relies on fixed controller timing. It polls a status byte in which the controller's acknowledge level sits in bit 7 and its attention level sits in bit 6. A bit-test instruction therefore moves acknowledge into the sign flag and attention into the overflow flag.

The controller sends bytes back by placing them on its data bus and pulsing a strobe. It withdraws a pending request by pulsing a clear input. It may also hold the host through the CPU ready line. That hold is gated so it reaches the CPU only while the host is accessing this port, and it applies to reads and writes alike. Every controller-side input passes through a two-flop synchronizer into the host clock domain. An access counts as valid only while the PHI2 level is high.

The port has two offsets. Offset 0 is the data register: a write sends a byte to the controller, and a read returns the last byte received from it. Offset 1 is the status register, which can only be read. The `WAIT_EN` parameter decides whether the ready gating is built at all.

Top module: `mcu_bus_port`

## Requirements
- R1: A write (cs_n low, rw low, phi2 high) to offset 0 places the written byte on `mcu_tx_data` and sets `mcu_req` high. Both take effect at the first clock edge of the access.
- R2: `mcu_req` stays high until the controller pulses `mcu_req_clr`. The port sees the rising edge of that pulse after the two-flop synchronizer, and `mcu_req` falls on the clock after that. If a new data write arrives in the same cycle, the set takes priority.
- R3: A read of offset 1 returns the synchronized `mcu_ack` level in bit 7 and the synchronized `mcu_attn` level in bit 6. Bits 5 to 0 read as zero.
- R4: After reset, `mcu_req` is low, `mcu_tx_data` is 0x00, and the status byte reads 0x00. Acknowledge therefore starts in the not-acknowledged state.
- R5: A rising edge on `mcu_rd_stb`, seen after synchronization, captures the synchronized `mcu_rd_data`. A read of offset 0 then returns that byte until the next strobe.
- R6: `data_oe` is high only while cs_n is low, rw is high and phi2 is high. At every other time the port leaves the data bus undriven.
- R7: A write presented while phi2 is low has no effect on `mcu_tx_data` or `mcu_req`.
- R8: A write to offset 1 leaves `mcu_tx_data` and `mcu_req` unchanged.
- R9: `cpu_rdy` goes low only while the port is selected (cs_n low, phi2 high) and the synchronized `mcu_wait` level is high. This holds for both reads and writes. Otherwise `cpu_rdy` is high.
- R10: With `WAIT_EN` = 0, `cpu_rdy` stays high whatever the state of `mcu_wait`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi2 | input | 1 | Host bus phase-2 level; an access is valid only while it is high |
| cs_n | input | 1 | Active-low port select |
| rw | input | 1 | 1 = host read, 0 = host write |
| addr | input | 1 | Register offset: 0 = data, 1 = status |
| wdata | input | 8 | Host write data |
| data_out | output | 8 | Host read data |
| data_oe | output | 1 | Drive enable for `data_out` |
| cpu_rdy | output | 1 | CPU ready; low holds the host |
| mcu_tx_data | output | 8 | Byte latched for the controller |
| mcu_req | output | 1 | Request level toward the controller |
| mcu_req_clr | input | 1 | Controller pulse that clears the request |
| mcu_rd_data | input | 8 | Byte from the controller |
| mcu_rd_stb | input | 1 | Strobe that loads `mcu_rd_data` |
| mcu_ack | input | 1 | Controller acknowledge level |
| mcu_attn | input | 1 | Controller attention level |
| mcu_wait | input | 1 | Controller request to stall the host |

## Verification
The bench first checks that the request survives the synchronizer delay of a clear pulse, and that a clear does not drop it too early. A design that cleared the request from the raw pulse would fail that check. It also checks that a write to the status offset, or a write made while phi2 is low, leaves the command byte and the request untouched. A careless decode would overwrite the byte or raise a false request there. Further checks confirm that the stall appears only while the port is selected, for reads and writes alike, and never when a second instance is built without the wait path. An ungated ready line would freeze the CPU on unrelated bus cycles. Finally, the bench confirms that acknowledge and attention sit in bits 7 and 6, and that the status byte reads zero after reset.

// File: rtl/mbp_pkg.sv
package mbp_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam logic        OFF_DATA = 1'b0;
  localparam logic        OFF_STAT = 1'b1;
  localparam int unsigned ACK_BIT  = 7;
  localparam int unsigned ATTN_BIT = 6;
endpackage

// File: rtl/mbp_sync.sv
module mbp_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[gi] <= '0;
          else        chain[gi] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[gi] <= '0;
          else        chain[gi] <= chain[gi-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mbp_mcu_rx.sv
module mbp_mcu_rx
  import mbp_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] mcu_rd_data,
  input  logic              mcu_rd_stb,
  input  logic              mcu_ack,
  input  logic              mcu_attn,
  input  logic              mcu_req_clr,
  input  logic              mcu_wait,
  output logic [DATA_W-1:0] rx_data,
  output logic              ack_s,
  output logic              attn_s,
  output logic              wait_s,
  output logic              clr_edge
);
  localparam int unsigned CTRL_W = 5;

  logic [DATA_W-1:0] data_s;
  logic [CTRL_W-1:0] ctrl_s;
  logic              stb_s, clr_s;
  logic              stb_prev_q, clr_prev_q;
  logic              stb_edge;
  logic [DATA_W-1:0] rx_q, rx_d;

  mbp_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_data_sync (
    .clk(clk), .rst_n(rst_n), .d(mcu_rd_data), .q(data_s)
  );

  mbp_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES)) u_ctrl_sync (
    .clk(clk), .rst_n(rst_n),
    .d({mcu_wait, mcu_req_clr, mcu_rd_stb, mcu_attn, mcu_ack}),
    .q(ctrl_s)
  );

  assign ack_s  = ctrl_s[0];
  assign attn_s = ctrl_s[1];
  assign stb_s  = ctrl_s[2];
  assign clr_s  = ctrl_s[3];
  assign wait_s = ctrl_s[4];

  assign stb_edge = stb_s & ~stb_prev_q;
  assign clr_edge = clr_s & ~clr_prev_q;

  always_comb begin
    rx_d = rx_q;
    if (stb_edge) rx_d = data_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_prev_q <= 1'b0;
      clr_prev_q <= 1'b0;
      rx_q       <= '0;
    end else begin
      stb_prev_q <= stb_s;
      clr_prev_q <= clr_s;
      rx_q       <= rx_d;
    end
  end

  assign rx_data = rx_q;

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_edge |=> $stable(rx_q)); // R5
endmodule

// File: rtl/mbp_host_if.sv
module mbp_host_if
  import mbp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phi2,
  input  logic              cs_n,
  input  logic              rw,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              ack_s,
  input  logic              attn_s,
  input  logic              clr_edge,
  output logic              sel,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic [DATA_W-1:0] tx_data,
  output logic              req
);
  logic              wr_data;
  logic [DATA_W-1:0] tx_q, tx_d;
  logic              req_q, req_d;
  logic [DATA_W-1:0] status;

  assign sel     = ~cs_n & phi2;
  assign wr_data = sel & ~rw & (addr == OFF_DATA);

  always_comb begin
    tx_d  = tx_q;
    req_d = req_q;
    if (clr_edge) req_d = 1'b0;
    if (wr_data) begin
      tx_d  = wdata;
      req_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      req_q <= 1'b0;
    end else begin
      tx_q  <= tx_d;
      req_q <= req_d;
    end
  end

  always_comb begin
    status           = '0;
    status[ACK_BIT]  = ack_s;
    status[ATTN_BIT] = attn_s;
  end

  assign data_oe  = sel & rw;
  assign data_out = (addr == OFF_STAT) ? status : rx_data;
  assign tx_data  = tx_q;
  assign req      = req_q;

  AST_REQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && phi2 && !rw && addr == OFF_DATA) |=> req); // R1
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !clr_edge) |=> req); // R2
  AST_STAT_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !rw && addr == OFF_STAT) |=> $stable(tx_q)); // R8
  AST_NO_WR_PHI2_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!phi2 && !clr_edge) |=> ($stable(tx_q) && $stable(req_q))); // R7
endmodule

// File: rtl/mbp_ready_gate.sv
module mbp_ready_gate #(
  parameter bit WAIT_EN = 1'b1
) (
  input  logic sel,
  input  logic wait_s,
  output logic cpu_rdy
);
  generate
    if (WAIT_EN) begin : g_gate
      assign cpu_rdy = ~(sel & wait_s);
    end else begin : g_none
      logic unused_in;
      assign unused_in = sel ^ wait_s;
      assign cpu_rdy   = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/mcu_bus_port.sv
module mcu_bus_port
  import mbp_pkg::*;
#(
  parameter bit          WAIT_EN     = 1'b1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phi2,
  input  logic              cs_n,
  input  logic              rw,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic              cpu_rdy,
  output logic [DATA_W-1:0] mcu_tx_data,
  output logic              mcu_req,
  input  logic              mcu_req_clr,
  input  logic [DATA_W-1:0] mcu_rd_data,
  input  logic              mcu_rd_stb,
  input  logic              mcu_ack,
  input  logic              mcu_attn,
  input  logic              mcu_wait
);
  logic              rst_sync_n;
  logic [DATA_W-1:0] rx_data;
  logic              ack_s, attn_s, wait_s, clr_edge, sel;

  mbp_sync #(.W(1), .STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sync_n)
  );

  mbp_mcu_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(rst_sync_n),
    .mcu_rd_data(mcu_rd_data), .mcu_rd_stb(mcu_rd_stb),
    .mcu_ack(mcu_ack), .mcu_attn(mcu_attn),
    .mcu_req_clr(mcu_req_clr), .mcu_wait(mcu_wait),
    .rx_data(rx_data), .ack_s(ack_s), .attn_s(attn_s),
    .wait_s(wait_s), .clr_edge(clr_edge)
  );

  mbp_host_if u_host (
    .clk(clk), .rst_n(rst_sync_n), .phi2(phi2), .cs_n(cs_n), .rw(rw),
    .addr(addr), .wdata(wdata), .rx_data(rx_data), .ack_s(ack_s),
    .attn_s(attn_s), .clr_edge(clr_edge), .sel(sel),
    .data_out(data_out), .data_oe(data_oe),
    .tx_data(mcu_tx_data), .req(mcu_req)
  );

  mbp_ready_gate #(.WAIT_EN(WAIT_EN)) u_rdy (
    .sel(sel), .wait_s(wait_s), .cpu_rdy(cpu_rdy)
  );

  AST_RDY_RELEASED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cs_n || !phi2) |-> cpu_rdy); // R9
  AST_OE_PHASE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!phi2 || cs_n || !rw) |-> !data_oe); // R6
endmodule

// File: tb/mcu_bus_port_tb.sv
module mcu_bus_port_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       phi2, cs_n, rw, addr;
  logic [7:0] wdata, data_out, mcu_tx_data, mcu_rd_data;
  logic       data_oe, cpu_rdy, mcu_req, mcu_req_clr, mcu_rd_stb;
  logic       mcu_ack, mcu_attn, mcu_wait;
  logic [7:0] data_out2, tx2;
  logic       oe2, rdy2, req2;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mcu_bus_port u_dut (
    .clk(clk), .rst_n(rst_n), .phi2(phi2), .cs_n(cs_n), .rw(rw),
    .addr(addr), .wdata(wdata), .data_out(data_out), .data_oe(data_oe),
    .cpu_rdy(cpu_rdy), .mcu_tx_data(mcu_tx_data), .mcu_req(mcu_req),
    .mcu_req_clr(mcu_req_clr), .mcu_rd_data(mcu_rd_data),
    .mcu_rd_stb(mcu_rd_stb), .mcu_ack(mcu_ack), .mcu_attn(mcu_attn),
    .mcu_wait(mcu_wait)
  );

  mcu_bus_port #(.WAIT_EN(1'b0)) u_dut_nowait (
    .clk(clk), .rst_n(rst_n), .phi2(phi2), .cs_n(cs_n), .rw(rw),
    .addr(addr), .wdata(wdata), .data_out(data_out2), .data_oe(oe2),
    .cpu_rdy(rdy2), .mcu_tx_data(tx2), .mcu_req(req2),
    .mcu_req_clr(mcu_req_clr), .mcu_rd_data(mcu_rd_data),
    .mcu_rd_stb(mcu_rd_stb), .mcu_ack(mcu_ack), .mcu_attn(mcu_attn),
    .mcu_wait(mcu_wait)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_bus();
    cs_n = 1'b1; rw = 1'b1; phi2 = 1'b0; addr = 1'b0; wdata = 8'h00;
  endtask

  task automatic host_write(input logic a, input logic [7:0] d, input logic ph);
    @(negedge clk);
    cs_n = 1'b0; rw = 1'b0; addr = a; wdata = d; phi2 = ph;
    @(negedge clk);
    idle_bus();
  endtask

  task automatic host_read(input logic a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    cs_n = 1'b0; rw = 1'b1; addr = a; phi2 = 1'b1;
    #1 d = data_out; oe = data_oe;
    @(negedge clk);
    idle_bus();
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d; logic oe;
    check("R4 req", {7'd0, mcu_req}, 8'h00);
    check("R4 tx", mcu_tx_data, 8'h00);
    host_read(1'b1, d, oe);
    check("R4 status", d, 8'h00);
  endtask

  task automatic t_write_req();
    host_write(1'b0, 8'hA5, 1'b1);
    check("R1 tx", mcu_tx_data, 8'hA5);
    check("R1 req", {7'd0, mcu_req}, 8'h01);
  endtask

  task automatic t_clear();
    @(negedge clk); mcu_req_clr = 1'b1;
    @(negedge clk); mcu_req_clr = 1'b0;
    check("R2 req held before sync", {7'd0, mcu_req}, 8'h01);
    wait_neg(4);
    check("R2 req cleared", {7'd0, mcu_req}, 8'h00);
  endtask

  task automatic t_ignored_writes();
    host_write(1'b1, 8'h3C, 1'b1);
    check("R8 tx", mcu_tx_data, 8'hA5);
    check("R8 req", {7'd0, mcu_req}, 8'h00);
    host_write(1'b0, 8'h66, 1'b0);
    check("R7 tx", mcu_tx_data, 8'hA5);
    check("R7 req", {7'd0, mcu_req}, 8'h00);
  endtask

  task automatic t_status();
    logic [7:0] d; logic oe;
    @(negedge clk); mcu_ack = 1'b1; mcu_attn = 1'b0;
    wait_neg(3);
    host_read(1'b1, d, oe);
    check("R3 ack bit7", d, 8'h80);
    @(negedge clk); mcu_ack = 1'b0; mcu_attn = 1'b1;
    wait_neg(3);
    host_read(1'b1, d, oe);
    check("R3 attn bit6", d, 8'h40);
    @(negedge clk); mcu_attn = 1'b0;
    wait_neg(3);
  endtask

  task automatic t_rx();
    logic [7:0] d; logic oe;
    @(negedge clk); mcu_rd_data = 8'h5E; mcu_rd_stb = 1'b1;
    wait_neg(2); mcu_rd_stb = 1'b0;
    wait_neg(3);
    mcu_rd_data = 8'hFF;
    wait_neg(4);
    host_read(1'b0, d, oe);
    check("R5 rx byte", d, 8'h5E);
    check("R6 oe on read", {7'd0, oe}, 8'h01);
  endtask

  task automatic t_oe();
    @(negedge clk); cs_n = 1'b0; rw = 1'b1; phi2 = 1'b0;
    #1 check("R6 oe phi2 low", {7'd0, data_oe}, 8'h00);
    phi2 = 1'b1; rw = 1'b0;
    #1 check("R6 oe on write", {7'd0, data_oe}, 8'h00);
    @(negedge clk); idle_bus();
  endtask

  task automatic t_ready();
    @(negedge clk); mcu_wait = 1'b1;
    wait_neg(3);
    #1 check("R9 rdy unselected", {7'd0, cpu_rdy}, 8'h01);
    cs_n = 1'b0; rw = 1'b1; addr = 1'b0; phi2 = 1'b1;
    #1 check("R9 rdy read stall", {7'd0, cpu_rdy}, 8'h00);
    check("R10 no wait path", {7'd0, rdy2}, 8'h01);
    rw = 1'b0; addr = 1'b1;
    #1 check("R9 rdy write stall", {7'd0, cpu_rdy}, 8'h00);
    phi2 = 1'b0;
    #1 check("R9 rdy phi2 low", {7'd0, cpu_rdy}, 8'h01);
    @(negedge clk); idle_bus(); mcu_wait = 1'b0;
    wait_neg(3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_bus();
    mcu_req_clr = 1'b0; mcu_rd_data = 8'h00; mcu_rd_stb = 1'b0;
    mcu_ack = 1'b0; mcu_attn = 1'b0; mcu_wait = 1'b0;
    rst_n = 1'b0;
    wait_neg(3);
    rst_n = 1'b1;
    wait_neg(4);
    t_reset();
    t_write_req();
    t_clear();
    t_ignored_writes();
    t_status();
    t_rx();
    t_oe();
    t_ready();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule